// File: doc/BRIEF.md
# Checkerboard and Gradient Pattern Source

This block creates 24-bit RGB test pixels in step with an external timing generator. The timing generator supplies the data-enable (DE) and vertical sync (VS) strobes. The block decides, pixel by pixel, which colour or level to send out for each active pixel.

A two-bit mode input picks one of three behaviours:

- **Off:** the output stays quiet.
- **Checkerboard:** alternating runs of two programmed colours. Each colour has its own run length. The starting colour of each line flips after a programmed number of lines.
- **Ramp:** a level that rises by a programmed step on every active pixel and restarts on each line.

The output is registered, so it lags the timing strobes by one clock.

Timing generation, colour-space conversion and link packing sit outside this block. Software sets the mode and the pattern parameters while VS frames the picture, and leaves them unchanged while lines are being sent.

Top module: `pgen_pattern_src`

## Requirements
- R1: The mode encoding is 0 = off, 1 = checkerboard, 2 = ramp. Code 3 behaves as off. In off mode `pix_o` is zero and `pix_valid_o` is low on every cycle.
- R2: In checkerboard or ramp mode, `pix_valid_o` equals the `de_i` of the previous clock. Whenever `pix_valid_o` is low, `pix_o` is zero.
- R3: Both colour inputs are packed as blue in bits 23:16, green in bits 15:8 and red in bits 7:0. A selected colour appears on `pix_o` unchanged, in that same packing.
- R4: The first DE-high clock of a line restarts the run counter. That pixel takes colour A when the row phase is 0 and colour B when it is 1.
- R5: Within a line, the checkerboard shows `run_a_i` pixels of colour A and `run_b_i` pixels of colour B, alternating. A count of 0 acts as 1.
- R6: The row phase toggles each time `alt_lines_i` lines have completed, where a line completes at a falling edge of `de_i`. A count of 0 acts as 1.
- R7: A rising edge of `vs_i` clears both the row phase and the line counter. The first line of a frame therefore starts with colour A.
- R8: In ramp mode, the first pixel of each line has level 0. Each following pixel adds `grad_step_i` modulo 256. All three bytes of `pix_o` carry the same level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| de_i | input | 1 | Active-pixel strobe from the timing generator |
| vs_i | input | 1 | Vertical sync from the timing generator |
| mode_i | input | 2 | Pattern select (0 off, 1 checkerboard, 2 ramp) |
| color_a_i | input | 24 | First checkerboard colour, packed {B,G,R} |
| color_b_i | input | 24 | Second checkerboard colour, packed {B,G,R} |
| run_a_i | input | 8 | Pixels per colour A run |
| run_b_i | input | 8 | Pixels per colour B run |
| alt_lines_i | input | 8 | Lines between row-phase swaps |
| grad_step_i | input | 8 | Ramp increment per active pixel |
| pix_o | output | 24 | Registered pixel value |
| pix_valid_o | output | 1 | Registered pixel qualifier |

## Verification
The properties assume that the mode and the ramp step stay unchanged while lines are being sent, and change only around a vertical sync. The ramp-increment property relies on this in particular, because it compares two consecutive outputs against a step sampled two clocks earlier. The stimulus changes mode, colours, run counts, line count and step only between frames, while DE is low. Inside each frame the stimulus uses randomly chosen line widths, blanking lengths and line counts. Directed frames add zero counts, the reserved mode code and a ramp step that wraps on every pixel.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    PG_OFF     = 2'd0,
    PG_CHECKER = 2'd1,
    PG_RAMP    = 2'd2,
    PG_RSVD    = 2'd3
  } pg_mode_e;
endpackage

// File: rtl/pgen_line_track.sv
module pgen_line_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_i,
  input  logic             vs_i,
  input  logic [CNT_W-1:0] alt_lines_i,
  output logic             line_start_o,
  output logic             row_phase_o
);
  logic             de_q, vs_q;
  logic             phase_q, phase_d;
  logic [CNT_W-1:0] lcnt_q, lcnt_d;
  logic             de_fall, vs_rise, last_line;

  always_comb begin
    line_start_o = de_i & ~de_q;
    de_fall      = de_q & ~de_i;
    vs_rise      = vs_i & ~vs_q;
    last_line    = (alt_lines_i == '0) || (lcnt_q == alt_lines_i - 1'b1);
    phase_d      = phase_q;
    lcnt_d       = lcnt_q;
    if (vs_rise) begin
      phase_d = 1'b0;
      lcnt_d  = '0;
    end else if (de_fall) begin
      if (last_line) begin
        phase_d = ~phase_q;
        lcnt_d  = '0;
      end else begin
        lcnt_d = lcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q    <= 1'b0;
      vs_q    <= 1'b0;
      phase_q <= 1'b0;
      lcnt_q  <= '0;
    end else begin
      de_q    <= de_i;
      vs_q    <= vs_i;
      phase_q <= phase_d;
      lcnt_q  <= lcnt_d;
    end
  end

  assign row_phase_o = phase_q;
endmodule

// File: rtl/pgen_checker.sv
module pgen_checker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             de_i,
  input  logic             line_start_i,
  input  logic             row_phase_i,
  input  logic [CNT_W-1:0] run_a_i,
  input  logic [CNT_W-1:0] run_b_i,
  output logic             sel_b_o
);
  logic             sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cur_sel, run_end;
  logic [CNT_W-1:0] cur_cnt, cur_len;

  always_comb begin
    cur_sel = line_start_i ? row_phase_i : sel_q;
    cur_cnt = line_start_i ? '0 : cnt_q;
    cur_len = cur_sel ? run_b_i : run_a_i;
    run_end = (cur_len == '0) || (cur_cnt == cur_len - 1'b1);
    if (run_end) begin
      sel_d = ~cur_sel;
      cnt_d = '0;
    end else begin
      sel_d = cur_sel;
      cnt_d = cur_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else if (de_i) begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign sel_b_o = cur_sel;
endmodule

// File: rtl/pgen_ramp.sv
module pgen_ramp #(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            de_i,
  input  logic            line_start_i,
  input  logic [CH_W-1:0] step_i,
  output logic [CH_W-1:0] level_o
);
  logic [CH_W-1:0] lvl_q, lvl_d, cur_lvl;

  always_comb begin
    cur_lvl = line_start_i ? '0 : lvl_q;
    lvl_d   = cur_lvl + step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else if (de_i) lvl_q <= lvl_d;
  end

  assign level_o = cur_lvl;
endmodule

// File: rtl/pgen_pattern_src.sv
module pgen_pattern_src
  import pgen_pkg::*;
#(
  parameter int COLOR_W = 24,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               de_i,
  input  logic               vs_i,
  input  logic [1:0]         mode_i,
  input  logic [COLOR_W-1:0] color_a_i,
  input  logic [COLOR_W-1:0] color_b_i,
  input  logic [CNT_W-1:0]   run_a_i,
  input  logic [CNT_W-1:0]   run_b_i,
  input  logic [CNT_W-1:0]   alt_lines_i,
  input  logic [COLOR_W/3-1:0] grad_step_i,
  output logic [COLOR_W-1:0] pix_o,
  output logic               pix_valid_o
);
  localparam int CH_W = COLOR_W / 3;

  pg_mode_e         mode;
  logic             line_start, row_phase, sel_b;
  logic [CH_W-1:0]  level;
  logic [COLOR_W-1:0] ramp_word, pix_d;
  logic             valid_d;

  pgen_line_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .de_i(de_i), .vs_i(vs_i),
    .alt_lines_i(alt_lines_i), .line_start_o(line_start),
    .row_phase_o(row_phase)
  );

  pgen_checker #(.CNT_W(CNT_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .de_i(de_i), .line_start_i(line_start),
    .row_phase_i(row_phase), .run_a_i(run_a_i), .run_b_i(run_b_i),
    .sel_b_o(sel_b)
  );

  pgen_ramp #(.CH_W(CH_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .de_i(de_i), .line_start_i(line_start),
    .step_i(grad_step_i), .level_o(level)
  );

  for (genvar c = 0; c < 3; c++) begin : g_ramp_ch
    assign ramp_word[c*CH_W +: CH_W] = level;
  end

  always_comb begin
    mode    = pg_mode_e'(mode_i);
    valid_d = de_i && (mode == PG_CHECKER || mode == PG_RAMP);
    pix_d   = '0;
    if (valid_d) begin
      if (mode == PG_CHECKER) pix_d = sel_b ? color_b_i : color_a_i;
      else                    pix_d = ramp_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_o       <= '0;
      pix_valid_o <= 1'b0;
    end else begin
      pix_o       <= pix_d;
      pix_valid_o <= valid_d;
    end
  end
endmodule

// File: rtl/pgen_pattern_src_chk.sv
module pgen_pattern_src_chk #(
  parameter int COLOR_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               de_i,
  input logic [1:0]         mode_i,
  input logic [COLOR_W/3-1:0] grad_step_i,
  input logic [COLOR_W-1:0] pix_o,
  input logic               pix_valid_o
);
  localparam int CH_W = COLOR_W / 3;

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 || mode_i == 2'd3) |=> (!pix_valid_o && pix_o == '0));

  p_valid_tracks_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i && (mode_i == 2'd1 || mode_i == 2'd2)) |=> pix_valid_o);

  p_no_de_no_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !de_i |=> !pix_valid_o);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid_o |-> pix_o == '0);

  p_ramp_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && de_i && !$past(de_i)) |=> pix_o == '0);

  p_ramp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2 && $past(mode_i) == 2'd2 && de_i && $past(de_i))
      |=> pix_o[CH_W-1:0] == CH_W'($past(pix_o[CH_W-1:0]) + $past(grad_step_i, 2)));
endmodule

bind pgen_pattern_src pgen_pattern_src_chk #(.COLOR_W(COLOR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .de_i(de_i), .mode_i(mode_i),
  .grad_step_i(grad_step_i), .pix_o(pix_o), .pix_valid_o(pix_valid_o)
);

// File: tb/pgen_pattern_src_tb.sv
module pgen_pattern_src_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        de_i, vs_i;
  logic [1:0]  mode_i;
  logic [23:0] color_a_i, color_b_i;
  logic [7:0]  run_a_i, run_b_i, alt_lines_i, grad_step_i;
  logic [23:0] pix_o;
  logic        pix_valid_o;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  bit    armed  = 0;
  logic        ev;
  logic [23:0] ep;
  string       etag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgen_pattern_src dut_i (
    .clk(clk), .rst_n(rst_n), .de_i(de_i), .vs_i(vs_i), .mode_i(mode_i),
    .color_a_i(color_a_i), .color_b_i(color_b_i), .run_a_i(run_a_i),
    .run_b_i(run_b_i), .alt_lines_i(alt_lines_i), .grad_step_i(grad_step_i),
    .pix_o(pix_o), .pix_valid_o(pix_valid_o)
  );

  function automatic bit exp_sel_b(int k, bit ph, int ra, int rb);
    int la = (ra == 0) ? 1 : ra;
    int lb = (rb == 0) ? 1 : rb;
    bit s = ph;
    int c = 0;
    for (int i = 0; i < k; i++) begin
      c++;
      if (c >= (s ? lb : la)) begin
        s = ~s;
        c = 0;
      end
    end
    return s;
  endfunction

  function automatic bit exp_phase(int l, int alt);
    int a = (alt == 0) ? 1 : alt;
    return bit'((l / a) % 2);
  endfunction

  task automatic check(input logic v, input logic [23:0] p, input string tag);
    checks++;
    if (pix_valid_o !== v || pix_o !== p) begin
      errors++;
      $display("FAIL %s: actual valid=%0b pix=%06h expected valid=%0b pix=%06h",
               tag, pix_valid_o, pix_o, v, p);
    end
  endtask

  task automatic cyc(input logic de, input logic vs, input logic v,
                     input logic [23:0] p, input string tag);
    @(negedge clk);
    if (armed) check(ev, ep, etag);
    de_i = de; vs_i = vs;
    ev = v; ep = p; etag = tag; armed = 1;
  endtask

  task automatic frame(input logic [1:0] md, input int lines, input int width,
                       input int blank);
    bit          act;
    logic [23:0] val;
    string       tag;
    mode_i = md;
    act = (md == 2'd1) || (md == 2'd2);
    cyc(0, 1, 0, '0, "R2 vsync");
    cyc(0, 1, 0, '0, "R2 vsync");
    cyc(0, 0, 0, '0, "R2 blank");
    for (int l = 0; l < lines; l++) begin
      for (int k = 0; k < width; k++) begin
        if (md == 2'd1) begin
          val = exp_sel_b(k, exp_phase(l, alt_lines_i), run_a_i, run_b_i)
                ? color_b_i : color_a_i;
          if (k == 0 && l == 0) tag = "R7 frame start colour";
          else if (k == 0)      tag = "R4 R6 line start phase";
          else                  tag = "R3 R5 checker run";
        end else if (md == 2'd2) begin
          val = {3{8'((k * grad_step_i) % 256)}};
          tag = "R8 ramp level";
        end else begin
          val = '0;
          tag = "R1 off mode";
        end
        cyc(1, 0, act, act ? val : 24'h0, tag);
      end
      for (int b = 0; b < blank; b++) cyc(0, 0, 0, '0, "R2 blank zero");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    rst_n = 0; de_i = 0; vs_i = 0; mode_i = 2'd1;
    color_a_i = 24'h12AB34; color_b_i = 24'hC05A77;
    run_a_i = 8'd3; run_b_i = 8'd2; alt_lines_i = 8'd2; grad_step_i = 8'd16;
    repeat (3) @(negedge clk);
    check(0, '0, "R2 reset state");
    rst_n = 1;

    // directed checkerboard, distinct run lengths
    frame(2'd1, 6, 12, 3);
    // zero counts act as one
    run_a_i = 8'd0; run_b_i = 8'd0; alt_lines_i = 8'd0;
    frame(2'd1, 4, 7, 2);
    // ramp, wraps every pixel with 255
    grad_step_i = 8'd255;
    frame(2'd2, 3, 10, 2);
    grad_step_i = 8'd16;
    frame(2'd2, 2, 20, 4);
    // off and reserved codes
    frame(2'd0, 2, 8, 2);
    frame(2'd3, 2, 8, 2);

    for (int f = 0; f < 10; f++) begin
      color_a_i   = 24'($urandom);
      color_b_i   = 24'($urandom);
      run_a_i     = 8'($urandom_range(0, 7));
      run_b_i     = 8'($urandom_range(0, 7));
      alt_lines_i = 8'($urandom_range(0, 3));
      grad_step_i = 8'($urandom);
      frame(2'($urandom_range(0, 3)), $urandom_range(3, 8),
            $urandom_range(5, 40), $urandom_range(1, 6));
    end
    cyc(0, 0, 0, '0, "R2 tail");
    cyc(0, 0, 0, '0, "R2 tail");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule